// File: doc/BRIEF.md
# Next Program Counter and Link Unit

This block holds the program counter of a 64-bit integer core and works out, every cycle, where execution goes next. An instruction class select picks among sequential flow, the direct jump-and-link, the register-indirect jump-and-link, six conditional branches and the add-upper-immediate-to-PC operation. The inputs are two register operands and a sign-extended offset. The block returns the next PC, a result value for the destination register, and a write strobe for that register. The PC register loads the next PC on every rising clock edge.

Decode supplies the offset already sign-extended to 64 bits. For the add-upper-immediate-to-PC class, that offset is the 20-bit immediate shifted left by 12 and sign-extended. Fetch, decode and trap handling live elsewhere. They read the PC from `pcOut` and feed the decoded class and operands back in the same cycle.

The control half turns the class and the comparison flags into a small set of strobes. The datapath half holds the PC, the adders and the comparators.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset that is high at a rising edge sets the PC to 0x0, and `pcOut` shows the PC.
- R2: Class code 0 (sequential) and the unused codes 10 to 15 give a next PC of PC+4, with `rdWe` low. The PC takes the next PC at every rising edge when reset is low.
- R3: Class code 1 (direct jump) gives a next PC of PC+offset, a result of PC+4, and `rdWe` high.
- R4: Class code 2 (indirect jump) gives a next PC of rs1+offset with bit 0 forced to 0. Its result is PC+4 of the old PC, independent of rs1, and `rdWe` is high.
- R5: Class code 3 is taken when rs1 equals rs2, and class code 4 is taken when they differ.
- R6: Class code 5 is taken when rs1 < rs2 as two's-complement numbers, and class code 6 is taken otherwise.
- R7: Class code 7 is taken when rs1 < rs2 as unsigned numbers, and class code 8 is taken otherwise.
- R8: A taken conditional branch gives a next PC of PC+offset. A branch that is not taken gives PC+4.
- R9: Conditional branches (codes 3 to 8) never raise `rdWe`.
- R10: Class code 9 (add upper immediate to PC) gives a result of PC+offset, a next PC of PC+4, and `rdWe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insClass | input | 4 | Instruction class select |
| rs1Val | input | 64 | First register operand |
| rs2Val | input | 64 | Second register operand |
| offset | input | 64 | Sign-extended offset or shifted upper immediate |
| pcOut | output | 64 | Current PC |
| nextPc | output | 64 | PC that will be loaded at the next edge |
| linkVal | output | 64 | Value for the destination register |
| rdWe | output | 1 | Destination register write enable |

## Verification
Each of the six conditional branch classes is swept over every ordered pair drawn from a set of operands: zero, one, all ones, the most negative value, the most positive value and a small positive number. Equal pairs separate the equal from the strict-less forms. The most-negative against most-positive pairs and the all-ones against one pairs separate the signed order from the unsigned order. The branch offset alternates sign, so forward and backward targets both appear. The jumps are driven with even and odd register-plus-offset sums, the latter to show the bit-0 clear, and the sequential, unused and upper-immediate classes confirm the PC+4 flow and the write strobe.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CLS_SEQ   = 4'd0,
    CLS_JAL   = 4'd1,
    CLS_JALR  = 4'd2,
    CLS_BEQ   = 4'd3,
    CLS_BNE   = 4'd4,
    CLS_BLT   = 4'd5,
    CLS_BGE   = 4'd6,
    CLS_BLTU  = 4'd7,
    CLS_BGEU  = 4'd8,
    CLS_AUIPC = 4'd9
  } ctlClass_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic redirect;    // next PC is a computed target
    logic useRegBase;  // target base is rs1 (else PC)
    logic resultIsSum; // result is PC+offset (else PC+step)
    logic wrEn;        // destination write
  } npcStrobe_t;
endpackage

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CLASS_W-1:0] cls,
  input  logic               isEq,
  input  logic               isLtS,
  input  logic               isLtU,
  output npcStrobe_t         strb
);
  logic taken;

  always_comb begin
    case (cls)
      CLS_BEQ:  taken = isEq;
      CLS_BNE:  taken = !isEq;
      CLS_BLT:  taken = isLtS;
      CLS_BGE:  taken = !isLtS;
      CLS_BLTU: taken = isLtU;
      CLS_BGEU: taken = !isLtU;
      default:  taken = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    case (cls)
      CLS_JAL: begin
        strb.redirect = 1'b1;
        strb.wrEn     = 1'b1;
      end
      CLS_JALR: begin
        strb.redirect   = 1'b1;
        strb.useRegBase = 1'b1;
        strb.wrEn       = 1'b1;
      end
      CLS_BEQ, CLS_BNE, CLS_BLT, CLS_BGE, CLS_BLTU, CLS_BGEU:
        strb.redirect = taken;
      CLS_AUIPC: begin
        strb.resultIsSum = 1'b1;
        strb.wrEn        = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  assert_signed_lt_R6: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_BLT) |-> (strb.redirect == isLtS));
  assert_unsigned_ge_R7: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_BGEU) |-> (strb.redirect == !isLtU));
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  npcStrobe_t      strb,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  input  logic [XLEN-1:0] offset,
  output logic            isEq,
  output logic            isLtS,
  output logic            isLtU,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkVal
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(1);

  logic [XLEN-1:0] pcStep, pcTarget, regTarget;

  assign pcStep    = pcQ + STEP;
  assign pcTarget  = pcQ + offset;
  assign regTarget = (rs1Val + offset) & ALIGN_MASK;

  assign isEq  = (rs1Val == rs2Val);
  assign isLtS = ($signed(rs1Val) < $signed(rs2Val));
  assign isLtU = (rs1Val < rs2Val);

  always_comb begin
    if (!strb.redirect)       nextPc = pcStep;
    else if (strb.useRegBase) nextPc = regTarget;
    else                      nextPc = pcTarget;
  end

  assign linkVal = strb.resultIsSum ? pcTarget : pcStep;

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_PC;
    else     pcQ <= nextPc;
  end

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pcQ == RESET_PC));
  assert_even_target_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.redirect && strb.useRegBase) |-> (nextPc[0] == 1'b0));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CLASS_W-1:0] insClass,
  input  logic [XLEN-1:0]    rs1Val,
  input  logic [XLEN-1:0]    rs2Val,
  input  logic [XLEN-1:0]    offset,
  output logic [XLEN-1:0]    pcOut,
  output logic [XLEN-1:0]    nextPc,
  output logic [XLEN-1:0]    linkVal,
  output logic               rdWe
);
  npcStrobe_t strb;
  logic isEq, isLtS, isLtU;

  npc_control u_control (
    .clk(clk), .rst(rst), .cls(insClass),
    .isEq(isEq), .isLtS(isLtS), .isLtU(isLtU), .strb(strb)
  );

  npc_datapath #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .RESET_PC('0)) u_datapath (
    .clk(clk), .rst(rst), .strb(strb),
    .rs1Val(rs1Val), .rs2Val(rs2Val), .offset(offset),
    .isEq(isEq), .isLtS(isLtS), .isLtU(isLtU),
    .pcQ(pcOut), .nextPc(nextPc), .linkVal(linkVal)
  );

  assign rdWe = strb.wrEn;

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (insClass == CLS_SEQ) |-> (nextPc == pcOut + XLEN'(INSN_BYTES)));
  assert_branch_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (insClass >= CLS_BEQ && insClass <= CLS_BGEU) |-> !rdWe);
  assert_auipc_sum_R10: assert property (@(posedge clk) disable iff (rst)
    (insClass == CLS_AUIPC) |-> (linkVal == pcOut + offset && rdWe));
  assert_jal_link_R3: assert property (@(posedge clk) disable iff (rst)
    (insClass == CLS_JAL) |-> (linkVal == pcOut + XLEN'(INSN_BYTES)));
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst;
  logic [3:0]  insClass;
  logic [63:0] rs1Val, rs2Val, offset;
  logic [63:0] pcOut, nextPc, linkVal;
  logic        rdWe;

  int checks = 0;
  int errors = 0;
  logic [63:0] modelPc;

  npc_unit u_npc_unit (
    .clk(clk), .rst(rst), .insClass(insClass), .rs1Val(rs1Val),
    .rs2Val(rs2Val), .offset(offset), .pcOut(pcOut), .nextPc(nextPc),
    .linkVal(linkVal), .rdWe(rdWe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic taken(int cls, logic [63:0] a, logic [63:0] b);
    case (cls)
      3: return a == b;
      4: return a != b;
      5: return $signed(a) < $signed(b);
      6: return !($signed(a) < $signed(b));
      7: return a < b;
      8: return !(a < b);
      default: return 1'b0;
    endcase
  endfunction

  // Drive one instruction, check combinational outputs, clock, check PC
  task automatic step(string req, int cls, logic [63:0] a, logic [63:0] b, logic [63:0] off);
    logic [63:0] expNext, expLink;
    logic expWe;
    insClass = 4'(cls); rs1Val = a; rs2Val = b; offset = off;
    expLink = modelPc + 64'd4;
    expWe = 1'b0;
    expNext = modelPc + 64'd4;
    if (cls == 1) begin expNext = modelPc + off; expWe = 1'b1; end
    else if (cls == 2) begin expNext = (a + off) & ~64'd1; expWe = 1'b1; end
    else if (cls >= 3 && cls <= 8) begin if (taken(cls, a, b)) expNext = modelPc + off; end
    else if (cls == 9) begin expLink = modelPc + off; expWe = 1'b1; end
    #1;
    check64(req, nextPc, expNext);
    check64(req, {63'd0, rdWe}, {63'd0, expWe});
    if (expWe) check64(req, linkVal, expLink);
    @(negedge clk);
    check64(req, pcOut, expNext);
    modelPc = expNext;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] ops [6];
    ops[0] = 64'd0; ops[1] = 64'd1; ops[2] = '1;
    ops[3] = 64'h8000_0000_0000_0000; ops[4] = 64'h7FFF_FFFF_FFFF_FFFF; ops[5] = 64'd5;
    rst = 1; insClass = 0; rs1Val = 0; rs2Val = 0; offset = 0;
    @(negedge clk); @(negedge clk);
    check64("R1 reset", pcOut, 64'd0);
    rst = 0;
    modelPc = 64'd0;

    step("R2 sequential", 0, 64'd7, 64'd9, 64'h100);
    step("R2 sequential", 0, 64'd0, 64'd0, '1);
    for (int c = 10; c < 16; c++) step("R2 unused code", c, 64'd3, 64'd3, 64'h80);
    step("R3 jal forward", 1, 64'd0, 64'd0, 64'h1000);
    step("R3 jal backward", 1, 64'd0, 64'd0, -64'sd8);
    step("R4 jalr odd sum", 2, 64'h2001, 64'd0, 64'h10);
    step("R4 jalr even sum", 2, 64'h3000, 64'd0, 64'h24);
    step("R4 jalr odd via offset", 2, 64'h4000, 64'd0, -64'sd1);
    step("R10 auipc", 9, 64'd0, 64'd0, 64'h0000_0000_1234_5000);
    step("R10 auipc negative", 9, 64'd0, 64'd0, 64'hFFFF_FFFF_8000_0000);

    // R5 R6 R7 R8 R9: branch sweep over operand pairs
    for (int c = 3; c <= 8; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          string tag;
          tag = (c <= 4) ? "R5 R8 R9 equality" : (c <= 6) ? "R6 R8 R9 signed" : "R7 R8 R9 unsigned";
          step(tag, c, ops[i], ops[j], ((i + j) % 2 == 0) ? 64'h40 : -64'sd32);
        end

    rst = 1;
    @(negedge clk);
    check64("R1 reset mid-run", pcOut, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule